// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data-memory addresses for indirect accesses that use post-modify addressing, and keeps each pointer inside its circular buffer without extra cycles. Every pointer set holds four words: an index (the current pointer), a signed modifier (the step), a base (the first address of the buffer) and a length (the number of words in the buffer). When an access names a set, the block emits that set's current index as the address and, in the same clock edge, stores the stepped index folded back into the window `[base, base+length)`. The buffer can begin at any address and have any length, with no power-of-two alignment.

Two banks of `NSETS` pointer sets exist: a primary bank, which is live after reset, and a secondary bank that an interrupt handler can switch to for a fast context change. A small two-state machine holds the live bank. Its states are `LIVE_PRI` and `LIVE_SEC`. Transition `SELECT_SECONDARY` goes from `LIVE_PRI` to `LIVE_SEC` on a mode write with the alternate bit set. Transition `SELECT_PRIMARY` goes from `LIVE_SEC` to `LIVE_PRI` on a mode write with the bit clear. Any other input keeps the state. Register writes, register reads and accesses all go to the live bank, and the other bank keeps its contents.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset the primary bank is live, every register of both banks reads 0, and `addr_valid` is low.
- R2: An access emits the set's current index on `addr`. The index then becomes index plus the modifier, with the modifier read as a two's-complement signed value.
- R3: When length is non-zero and the stepped index is at or above base+length, length is subtracted from it. This holds for any base and length, aligned or not.
- R4: When length is non-zero and the stepped index is below base, length is added to it.
- R5: When length is 0 the index steps linearly, modulo 2^AW, with no folding.
- R6: A write to the base field also loads the index of the same set with the written value.
- R7: An access presented at a clock edge gives `addr_valid` high with its address after that edge. One access is accepted every cycle, and `addr_valid` is low after any edge with no access.
- R8: When a register write and an access name the same set in the same cycle, the access still emits the old index, but the index update from the access is dropped and the write takes effect. A write to a different set does not block the update.
- R9: A mode write with `mode_alt`=1 makes the secondary bank live from the next cycle, and a mode write with `mode_alt`=0 makes the primary bank live. Writes, reads and accesses use the live bank only, and switching banks leaves both banks' contents unchanged.
- R10: Field codes on `reg_fld` and `rd_fld` are 0 = index, 1 = modifier, 2 = base and 3 = length. `rd_data` returns the addressed field of the live bank combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_alt | input | 1 | Bank bit written by `mode_we` (1 = secondary) |
| reg_we | input | 1 | Pointer register write strobe |
| reg_fld | input | 2 | Field written (0 index, 1 modifier, 2 base, 3 length) |
| reg_set | input | SW | Set number written |
| reg_wdata | input | AW | Write data |
| rd_fld | input | 2 | Field read |
| rd_set | input | SW | Set number read |
| rd_data | output | AW | Read data from the live bank |
| acc_valid | input | 1 | Access request |
| acc_set | input | SW | Set number used by the access |
| addr_valid | output | 1 | Address output valid |
| addr | output | AW | Generated address (pre-modify index) |

## Verification
A register write and an access can fall in the same cycle. The bench provokes this by driving `reg_we` and `acc_valid` together on one set, first writing the index and then the modifier, and also on two different sets. The scoreboard expects the pre-write index on `addr`. The next access to that set must then show the written value, or the unchanged index when the write went to another field. On the different-set case it must show the normally stepped index.

// File: rtl/cag_pkg.sv
package cag_pkg;

    typedef enum logic [1:0] {
        FLD_INDEX  = 2'd0,
        FLD_MODIFY = 2'd1,
        FLD_BASE   = 2'd2,
        FLD_LENGTH = 2'd3
    } cag_field_e;

    typedef enum logic {
        LIVE_PRI = 1'b0,
        LIVE_SEC = 1'b1
    } cag_live_e;

    localparam int CAG_NUM_BANKS = 2;

endpackage

// File: rtl/cag_bank_fsm.sv
module cag_bank_fsm
    import cag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_we,
    input  logic mode_alt,
    output logic live_sec
);

    cag_live_e state_q, state_d;

    // next-state logic: SELECT_SECONDARY / SELECT_PRIMARY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LIVE_PRI: if (mode_we && mode_alt)  state_d = LIVE_SEC;
            LIVE_SEC: if (mode_we && !mode_alt) state_d = LIVE_PRI;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LIVE_PRI;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LIVE_PRI: live_sec = 1'b0;
            LIVE_SEC: live_sec = 1'b1;
        endcase
    end

endmodule

// File: rtl/cag_wrap.sv
module cag_wrap #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] modv,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);

    localparam int XW = AW + 2;

    logic signed [XW-1:0] sum_x, lim_x, base_x, len_x, dn_x, up_x;

    always_comb begin
        sum_x  = $signed({2'b00, idx}) + $signed({{2{modv[AW-1]}}, modv});
        base_x = $signed({2'b00, base});
        len_x  = $signed({2'b00, len});
        lim_x  = base_x + len_x;
        dn_x   = sum_x - len_x;
        up_x   = sum_x + len_x;
        if (len == '0)          nxt = sum_x[AW-1:0];
        else if (sum_x >= lim_x) nxt = dn_x[AW-1:0];
        else if (sum_x < base_x) nxt = up_x[AW-1:0];
        else                    nxt = sum_x[AW-1:0];
    end

endmodule

// File: rtl/cag_bank.sv
module cag_bank
    import cag_pkg::*;
#(
    parameter int NSETS = 8,
    parameter int AW    = 32,
    parameter int SW    = $clog2(NSETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_fld,
    input  logic [SW-1:0] wr_set,
    input  logic [AW-1:0] wr_data,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_set,
    input  logic [AW-1:0] upd_val,
    input  logic [1:0]    rd_fld,
    input  logic [SW-1:0] rd_set,
    output logic [AW-1:0] rd_data,
    input  logic [SW-1:0] acc_set,
    output logic [AW-1:0] acc_idx,
    output logic [AW-1:0] acc_mod,
    output logic [AW-1:0] acc_base,
    output logic [AW-1:0] acc_len
);

    logic [AW-1:0] idx_q  [NSETS];
    logic [AW-1:0] mod_q  [NSETS];
    logic [AW-1:0] base_q [NSETS];
    logic [AW-1:0] len_q  [NSETS];

    cag_field_e wfld;
    cag_field_e rfld;
    assign wfld = cag_field_e'(wr_fld);
    assign rfld = cag_field_e'(rd_fld);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                idx_q[s]  <= '0;
                mod_q[s]  <= '0;
                base_q[s] <= '0;
                len_q[s]  <= '0;
            end
        end else begin
            for (int s = 0; s < NSETS; s++) begin
                if (wr_en && wr_set == SW'(s)) begin
                    unique case (wfld)
                        FLD_INDEX:  idx_q[s] <= wr_data;
                        FLD_MODIFY: mod_q[s] <= wr_data;
                        FLD_BASE: begin
                            base_q[s] <= wr_data;
                            idx_q[s]  <= wr_data;
                        end
                        FLD_LENGTH: len_q[s] <= wr_data;
                    endcase
                end else if (upd_en && upd_set == SW'(s)) begin
                    idx_q[s] <= upd_val;
                end
            end
        end
    end

    always_comb begin
        unique case (rfld)
            FLD_INDEX:  rd_data = idx_q[rd_set];
            FLD_MODIFY: rd_data = mod_q[rd_set];
            FLD_BASE:   rd_data = base_q[rd_set];
            FLD_LENGTH: rd_data = len_q[rd_set];
        endcase
    end

    assign acc_idx  = idx_q[acc_set];
    assign acc_mod  = mod_q[acc_set];
    assign acc_base = base_q[acc_set];
    assign acc_len  = len_q[acc_set];

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import cag_pkg::*;
#(
    parameter  int NSETS = 8,
    parameter  int AW    = 32,
    localparam int SW    = $clog2(NSETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic          mode_alt,
    input  logic          reg_we,
    input  logic [1:0]    reg_fld,
    input  logic [SW-1:0] reg_set,
    input  logic [AW-1:0] reg_wdata,
    input  logic [1:0]    rd_fld,
    input  logic [SW-1:0] rd_set,
    output logic [AW-1:0] rd_data,
    input  logic          acc_valid,
    input  logic [SW-1:0] acc_set,
    output logic          addr_valid,
    output logic [AW-1:0] addr
);

    logic live_sec;

    cag_bank_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (mode_we),
        .mode_alt (mode_alt),
        .live_sec (live_sec)
    );

    logic [AW-1:0] bk_rd   [CAG_NUM_BANKS];
    logic [AW-1:0] bk_idx  [CAG_NUM_BANKS];
    logic [AW-1:0] bk_mod  [CAG_NUM_BANKS];
    logic [AW-1:0] bk_base [CAG_NUM_BANKS];
    logic [AW-1:0] bk_len  [CAG_NUM_BANKS];

    logic          upd_en;
    logic [AW-1:0] nxt_idx;
    logic [AW-1:0] acc_idx, acc_mod, acc_base, acc_len;

    // a write to the accessed set wins over the index update
    assign upd_en = acc_valid && !(reg_we && reg_set == acc_set);

    for (genvar b = 0; b < CAG_NUM_BANKS; b++) begin : g_bank
        localparam logic IS_SEC = (b == 1);
        logic bank_live;
        assign bank_live = (live_sec == IS_SEC);

        cag_bank #(.NSETS(NSETS), .AW(AW), .SW(SW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && bank_live),
            .wr_fld   (reg_fld),
            .wr_set   (reg_set),
            .wr_data  (reg_wdata),
            .upd_en   (upd_en && bank_live),
            .upd_set  (acc_set),
            .upd_val  (nxt_idx),
            .rd_fld   (rd_fld),
            .rd_set   (rd_set),
            .rd_data  (bk_rd[b]),
            .acc_set  (acc_set),
            .acc_idx  (bk_idx[b]),
            .acc_mod  (bk_mod[b]),
            .acc_base (bk_base[b]),
            .acc_len  (bk_len[b])
        );
    end

    assign rd_data  = live_sec ? bk_rd[1]   : bk_rd[0];
    assign acc_idx  = live_sec ? bk_idx[1]  : bk_idx[0];
    assign acc_mod  = live_sec ? bk_mod[1]  : bk_mod[0];
    assign acc_base = live_sec ? bk_base[1] : bk_base[0];
    assign acc_len  = live_sec ? bk_len[1]  : bk_len[0];

    cag_wrap #(.AW(AW)) u_wrap (
        .idx  (acc_idx),
        .modv (acc_mod),
        .base (acc_base),
        .len  (acc_len),
        .nxt  (nxt_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr       <= '0;
        end else begin
            addr_valid <= acc_valid;
            if (acc_valid) addr <= acc_idx;
        end
    end

endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_we,
    input logic          mode_alt,
    input logic          live_sec,
    input logic          acc_valid,
    input logic          addr_valid,
    input logic [AW-1:0] acc_idx,
    input logic [AW-1:0] acc_mod,
    input logic [AW-1:0] acc_base,
    input logic [AW-1:0] acc_len,
    input logic [AW-1:0] nxt_idx
);

    logic [AW:0]   lim;
    logic [AW-1:0] mag;
    logic          pre_in_win, post_in_win;

    always_comb begin
        lim         = {1'b0, acc_base} + {1'b0, acc_len};
        mag         = acc_mod[AW-1] ? (~acc_mod + 1'b1) : acc_mod;
        pre_in_win  = (acc_idx >= acc_base) && ({1'b0, acc_idx} < lim);
        post_in_win = (nxt_idx >= acc_base) && ({1'b0, nxt_idx} < lim);
    end

    // R7: each accepted access yields an address one cycle later
    p_valid_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> addr_valid);

    // R7: no address without a request
    p_idle_no_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !addr_valid);

    // R3 / R4: a pointer inside its window stays inside after the step
    p_stays_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_len != '0 && pre_in_win && mag <= acc_len) |-> post_in_win);

    // R9: mode write with the alternate bit selects the secondary bank
    p_select_sec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_alt) |=> live_sec);

    // R9: mode write with the bit clear selects the primary bank
    p_select_pri_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !mode_alt) |=> !live_sec);

    // R9: without a mode write the live bank holds
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(live_sec));

endmodule

bind circ_addr_gen cag_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_alt   (mode_alt),
    .live_sec   (live_sec),
    .acc_valid  (acc_valid),
    .addr_valid (addr_valid),
    .acc_idx    (acc_idx),
    .acc_mod    (acc_mod),
    .acc_base   (acc_base),
    .acc_len    (acc_len),
    .nxt_idx    (nxt_idx)
);

// File: tb/circ_addr_gen_test.sv
module circ_addr_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 8;
    localparam int AW    = 32;
    localparam int SW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0, mode_alt = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_fld = '0;
    logic [SW-1:0] reg_set = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [1:0]    rd_fld = '0;
    logic [SW-1:0] rd_set = '0;
    logic [AW-1:0] rd_data;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic          addr_valid;
    logic [AW-1:0] addr;

    circ_addr_gen #(.NSETS(NSETS), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_alt(mode_alt),
        .reg_we(reg_we), .reg_fld(reg_fld), .reg_set(reg_set), .reg_wdata(reg_wdata),
        .rd_fld(rd_fld), .rd_set(rd_set), .rd_data(rd_data),
        .acc_valid(acc_valid), .acc_set(acc_set),
        .addr_valid(addr_valid), .addr(addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // reference model of both banks
    logic [AW-1:0] m_idx  [2][NSETS];
    logic [AW-1:0] m_mod  [2][NSETS];
    logic [AW-1:0] m_base [2][NSETS];
    logic [AW-1:0] m_len  [2][NSETS];
    int m_live = 0;

    logic [AW-1:0] exp_q [$];
    string         tag_q [$];

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] step(input int b, input int s);
        longint i, m, bs, l, r;
        i  = longint'(m_idx[b][s]);
        m  = longint'($signed(m_mod[b][s]));
        bs = longint'(m_base[b][s]);
        l  = longint'(m_len[b][s]);
        r  = i + m;
        if (l != 0) begin
            if (r >= bs + l)  r = r - l;
            else if (r < bs)  r = r + l;
        end
        return r[AW-1:0];
    endfunction

    function automatic void model_write(input int f, input int s, input logic [AW-1:0] d);
        case (f)
            0: m_idx[m_live][s] = d;
            1: m_mod[m_live][s] = d;
            2: begin m_base[m_live][s] = d; m_idx[m_live][s] = d; end
            default: m_len[m_live][s] = d;
        endcase
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && addr_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R7: actual addr_valid=1 expected 0 (no pending access)");
            end else begin
                chk(tag_q.pop_front(), addr, exp_q.pop_front());
            end
        end
    end

    // drivers: called at a negedge, return at the next negedge
    task automatic wr(input int f, input int s, input logic [AW-1:0] d);
        reg_we = 1'b1; reg_fld = 2'(f); reg_set = SW'(s); reg_wdata = d;
        model_write(f, s, d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic acc(input int s, input string tag);
        exp_q.push_back(m_idx[m_live][s]);
        tag_q.push_back(tag);
        m_idx[m_live][s] = step(m_live, s);
        acc_valid = 1'b1; acc_set = SW'(s);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wr_acc(input int f, input int ws, input logic [AW-1:0] d,
                          input int as, input string tag);
        exp_q.push_back(m_idx[m_live][as]);
        tag_q.push_back(tag);
        if (ws != as) m_idx[m_live][as] = step(m_live, as);
        model_write(f, ws, d);
        reg_we = 1'b1; reg_fld = 2'(f); reg_set = SW'(ws); reg_wdata = d;
        acc_valid = 1'b1; acc_set = SW'(as);
        @(negedge clk);
        reg_we = 1'b0; acc_valid = 1'b0;
    endtask

    task automatic set_mode(input int alt);
        mode_we = 1'b1; mode_alt = alt[0];
        @(negedge clk);
        mode_we = 1'b0;
        m_live = alt;
    endtask

    task automatic rd(input int f, input int s, input string tag);
        logic [AW-1:0] e;
        rd_fld = 2'(f); rd_set = SW'(s);
        #1;
        case (f)
            0: e = m_idx[m_live][s];
            1: e = m_mod[m_live][s];
            2: e = m_base[m_live][s];
            default: e = m_len[m_live][s];
        endcase
        chk(tag, rd_data, e);
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < NSETS; s++) begin
                m_idx[b][s] = '0; m_mod[b][s] = '0; m_base[b][s] = '0; m_len[b][s] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 addr_valid", {31'd0, addr_valid}, 32'd0);
        rd(0, 0, "R1 index"); rd(3, 7, "R1 length"); rd(2, 4, "R1 base");

        // R10: field encoding and read-back
        wr(1, 1, 32'd3);          rd(1, 1, "R10 modifier");
        wr(3, 1, 32'd12);         rd(3, 1, "R10 length");
        wr(0, 1, 32'h55);         rd(0, 1, "R10 index");

        // R6: base write loads index
        wr(2, 0, 32'h13);         rd(0, 0, "R6 index from base"); rd(2, 0, "R10 base");

        // R2 / R3: unaligned buffer base 0x13 length 5, step +2
        wr(3, 0, 32'd5);
        wr(1, 0, 32'd2);
        for (int k = 0; k < 7; k++) acc(0, "R2/R3 upward wrap");
        drain();

        // R4: step -3 in buffer base 0x100 length 10
        wr(2, 2, 32'h100); wr(3, 2, 32'd10); wr(1, 2, 32'hFFFF_FFFD);
        for (int k = 0; k < 6; k++) acc(2, "R4 downward wrap");
        drain();

        // R5: length zero, linear with modular rollover
        wr(2, 3, 32'hFFFF_FFFE); wr(1, 3, 32'd3);
        for (int k = 0; k < 3; k++) acc(3, "R5 linear");
        drain();

        // R7: interleaved sets back to back
        for (int k = 0; k < 4; k++) begin
            acc(0, "R7 back-to-back");
            acc(2, "R7 back-to-back");
        end
        @(negedge clk);
        acc(1, "R7 single");
        drain();

        // R8: write and access colliding on one set
        wr_acc(0, 0, 32'h15, 0, "R8 old index on collision");
        acc(0, "R8 written index wins");
        wr_acc(1, 0, 32'd1, 0, "R8 modifier write collision");
        acc(0, "R8 index not advanced");
        acc(0, "R8 new modifier used");
        wr_acc(1, 5, 32'd9, 2, "R8 other set write");
        acc(2, "R8 update not blocked");
        drain();
        rd(1, 5, "R8 other set modifier");

        // R9: bank switching
        set_mode(1);
        rd(0, 0, "R9 secondary untouched");
        wr(2, 0, 32'h40); wr(3, 0, 32'd4); wr(1, 0, 32'd1);
        for (int k = 0; k < 5; k++) acc(0, "R9 secondary access");
        drain();
        set_mode(0);
        rd(0, 0, "R9 primary preserved");
        rd(3, 0, "R9 primary length");
        acc(0, "R9 primary access");
        drain();
        set_mode(1);
        rd(0, 0, "R9 secondary preserved");
        acc(0, "R9 secondary resumes");
        drain();

        chk("R7 queue empty", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule